// File: doc/BRIEF.md
# UART Register Front End with Divisor Aliasing

This block is the bus-facing register set of a 16550-style serial port. A peripheral bus reaches it with halfword accesses at a 4-byte register stride. It holds the divisor halves, interrupt enable, line and modem control, scratch and global control bytes. It reports line status by combining sticky status bits with live flags from the transmit and receive sides. The serial shifter, the baud generator and the FIFOs sit outside the block. The block talks to them through a byte-wide transmit strobe and a receive byte-take strobe.

Bit 7 of line control switches offsets 0 and 4 over to the divisor halves. A modem control bit selects loopback. In loopback, a transmitted byte is parked in a one-entry holding slot, and the next data read returns it instead of sending it out. The block raises single-cycle event pulses when a byte is written for transmit. It also raises them periodically while received data is waiting, each source gated by its own enable bit.

Top module: `uart_regfile`

## Requirements
- R1: After reset all registers read as zero, the holding slot is empty, and every strobe, error and event output is low.
- R2: An access whose size code is not halfword (size 1; 0 is byte, 2 is word) raises err_size one cycle later, never err_addr even at an unmapped offset, and changes no state.
- R3: A halfword access to an offset with nonzero low two bits, to index 8 (offset 32), or above index 9 raises err_addr one cycle later and reads zero.
- R4: With line-control bit 7 set, offset 0 reads and writes the low divisor byte and offset 4 the high divisor byte, without touching transmit or interrupt enable.
- R5: With line-control bit 7 clear, offset 4 is interrupt enable, and a write to offset 0 outside loopback pulses tx_valid for one cycle with tx_data equal to the low written byte.
- R6: Writes to the identification (offset 8), line status (offset 20) and modem status (offset 24) registers have no effect; identification and modem status read zero.
- R7: Line control (12), modem control (16), scratch (28) and global control (36) store the low 8 bits of a write and read them back with the upper byte zero.
- R8: With modem-control bit 4 set, a transmit write stores the byte in the holding slot and does not pulse tx_valid; the next data read returns it and empties the slot; further reads keep the previous value and ignore rx_avail without pulsing rx_take.
- R9: Outside loopback with an empty slot, a data read returns rx_data and pulses rx_take when rx_avail is high, and otherwise returns the previous received byte.
- R10: A line-status read ORs live status into the stored value and returns it: bit 0 when rx_avail or the slot holds a byte, bits 5 and 6 when tx_empty is high; bits once set stay set.
- R11: A transmit write pulses tx_evt for one cycle when interrupt-enable bit 1 is set, and not when it is clear.
- R12: While interrupt-enable bit 0 is set, receive status is sampled every POLL_CYCLES cycles and rx_evt pulses for one cycle when bit-0 status is present; clearing the bit stops all rx_evt pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_size | input | 2 | Size code: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after the request |
| err_size | output | 1 | Access size error pulse |
| err_addr | output | 1 | Unmapped register error pulse |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| tx_empty | input | 1 | Transmit side is empty |
| rx_avail | input | 1 | Receive side has a byte |
| rx_data | input | 8 | Received byte |
| rx_take | output | 1 | Received byte consumed |
| tx_evt | output | 1 | Transmit event pulse |
| rx_evt | output | 1 | Receive event pulse |

## Verification
The checker checks on every cycle that the error outputs are exclusive and follow their bus conditions, and that no transmit strobe or receive take ever leaves the block in loopback. It also checks that each event pulse follows its own enable bit. The directed scenarios alone can show the data side of the block. This covers the values returned through divisor aliasing and the byte returned by the holding slot. It also covers the sticky accumulation of line status and the number of receive events across a polling window.

// File: rtl/uart_regfile.sv
module uart_regfile #(
  parameter int ADDR_W = 6,
  parameter int POLL_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              err_size,
  output logic              err_addr,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_empty,
  input  logic              rx_avail,
  input  logic [7:0]        rx_data,
  output logic              rx_take,
  output logic              tx_evt,
  output logic              rx_evt
);
  localparam int CNT_W = $clog2(POLL_CYCLES + 1);

  logic [7:0] dll, dlh, ier, lcr, mcr, scr, gctl, lsr, rbr, hold;
  logic       hold_cnt;
  logic [CNT_W-1:0] poll_cnt;

  wire unused_wdata_hi = ^bus_wdata[15:8];
  wire [7:0] wb = bus_wdata[7:0];
  wire [ADDR_W-3:0] idx = bus_addr[ADDR_W-1:2];
  wire aligned = bus_addr[1:0] == 2'b00;
  wire mapped = aligned && (int'(idx) <= 7 || int'(idx) == 9);
  wire half = bus_size == 2'd1;
  wire go = bus_req && half && mapped;
  wire wr = go && bus_wr;
  wire rd = go && !bus_wr;
  wire dlab = lcr[7];
  wire loop = mcr[4];
  wire dr_live = hold_cnt | rx_avail;
  wire [7:0] live = {1'b0, tx_empty, tx_empty, 4'b0000, dr_live};
  wire rd_rbr = rd && int'(idx) == 0 && !dlab;
  wire wr_thr = wr && int'(idx) == 0 && !dlab;

  logic [7:0] rbr_next;
  logic       take_now;
  always_comb begin
    rbr_next = rbr;
    take_now = 1'b0;
    if (hold_cnt) rbr_next = hold;
    else if (!loop && rx_avail) begin
      rbr_next = rx_data;
      take_now = 1'b1;
    end
  end

  logic [7:0] rd_mux;
  always_comb begin
    case (int'(idx))
      0: rd_mux = dlab ? dll : rbr_next;
      1: rd_mux = dlab ? dlh : ier;
      3: rd_mux = lcr;
      4: rd_mux = mcr;
      5: rd_mux = lsr | live;
      7: rd_mux = scr;
      9: rd_mux = gctl;
      default: rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {dll, dlh, ier, lcr, mcr, scr, gctl, lsr, rbr, hold} <= '0;
      hold_cnt <= 1'b0;
      poll_cnt <= '0;
      bus_rdata <= '0;
      {err_size, err_addr, tx_valid, rx_take, tx_evt, rx_evt} <= '0;
      tx_data <= '0;
    end else begin
      err_size  <= bus_req && !half;
      err_addr  <= bus_req && half && !mapped;
      bus_rdata <= rd ? {8'h00, rd_mux} : 16'h0000;
      tx_valid  <= wr_thr && !loop;
      tx_evt    <= wr_thr && ier[1];
      rx_take   <= rd_rbr && take_now;
      rx_evt    <= 1'b0;

      if (wr_thr) begin
        if (loop) begin
          hold <= wb;
          hold_cnt <= 1'b1;
        end else tx_data <= wb;
      end
      if (rd_rbr) begin
        rbr <= rbr_next;
        if (hold_cnt) hold_cnt <= 1'b0;
      end
      if (rd && int'(idx) == 5) lsr <= lsr | live;

      if (wr) begin
        case (int'(idx))
          0: if (dlab) dll <= wb;
          1: if (dlab) dlh <= wb; else ier <= wb;
          3: lcr <= wb;
          4: mcr <= wb;
          7: scr <= wb;
          9: gctl <= wb;
          default: ;
        endcase
      end

      if (!ier[0]) poll_cnt <= '0;
      else if (poll_cnt == CNT_W'(POLL_CYCLES - 1)) begin
        poll_cnt <= '0;
        rx_evt <= dr_live;
      end else poll_cnt <= poll_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_size,
  input logic              err_size,
  input logic              err_addr,
  input logic              tx_valid,
  input logic              rx_take,
  input logic              tx_evt,
  input logic              rx_evt,
  input logic [7:0]        mcr,
  input logic [7:0]        ier
);
  assert_size_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_size != 2'd1 |=> err_size && !err_addr);

  assert_err_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_size && err_addr));

  assert_misaligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_size == 2'd1 && bus_addr[1:0] != 2'b00 |=> err_addr);

  assert_loop_no_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !$past(mcr[4]));

  assert_loop_no_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_take |-> !$past(mcr[4]));

  assert_tx_evt_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_evt |-> $past(ier[1]));

  assert_rx_evt_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_evt |-> $past(ier[0]));
endmodule

bind uart_regfile uart_regfile_chk #(.ADDR_W(ADDR_W)) chk (.*);

// File: tb/uart_regfile_test.sv
module uart_regfile_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req = 1'b0, bus_wr = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [1:0] bus_size = 2'd1;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic err_size, err_addr, tx_valid, rx_take, tx_evt, rx_evt;
  logic [7:0] tx_data;
  logic tx_empty = 1'b0, rx_avail = 1'b0;
  logic [7:0] rx_data = '0;

  int checks = 0, errors = 0;
  logic [15:0] c_rdata;
  logic c_esz, c_ead, c_txv, c_take, c_txe;
  logic [7:0] c_txd;

  always #10 clk = ~clk;

  uart_regfile uut (.*);

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic acc(input logic w, input int a, input int sz, input int d);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = w; bus_addr = 6'(a); bus_size = 2'(sz); bus_wdata = 16'(d);
    @(negedge clk);
    bus_req = 1'b0;
    c_rdata = bus_rdata; c_esz = err_size; c_ead = err_addr;
    c_txv = tx_valid; c_txd = tx_data; c_take = rx_take; c_txe = tx_evt;
  endtask

  task automatic wr(input int a, input int d); acc(1'b1, a, 1, d); endtask
  task automatic rd(input int a); acc(1'b0, a, 1, 0); endtask

  task automatic t_reset;
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 events", {tx_evt, rx_evt, rx_take}, 0);
    rd(12); chk("R1 line control", c_rdata, 0);
    rd(4);  chk("R1 enable", c_rdata, 0);
    rd(36); chk("R1 global", c_rdata, 0);
  endtask

  task automatic t_size;
    acc(1'b1, 12, 0, 16'h0083);
    chk("R2 err_size", c_esz, 1); chk("R2 no err_addr", c_ead, 0);
    acc(1'b0, 32, 2, 0);
    chk("R2 priority err_size", c_esz, 1); chk("R2 priority err_addr", c_ead, 0);
    rd(12); chk("R2 no effect", c_rdata, 0);
  endtask

  task automatic t_unmapped;
    rd(32); chk("R3 hole err", c_ead, 1); chk("R3 hole data", c_rdata, 0);
    rd(44); chk("R3 high index", c_ead, 1);
    wr(13, 16'h00FF); chk("R3 misaligned", c_ead, 1);
    chk("R3 no size err", c_esz, 0);
  endtask

  task automatic t_plain;
    wr(12, 16'h1203); rd(12); chk("R7 line control", c_rdata, 16'h0003);
    wr(16, 16'hFF0A); rd(16); chk("R7 modem control", c_rdata, 16'h000A);
    wr(28, 16'h00A5); rd(28); chk("R7 scratch", c_rdata, 16'h00A5);
    wr(36, 16'h775A); rd(36); chk("R7 global", c_rdata, 16'h005A);
    wr(16, 0);
  endtask

  task automatic t_dlab;
    wr(12, 16'h0083);
    wr(0, 16'h0034); chk("R4 no transmit", c_txv, 0);
    wr(4, 16'h0012);
    rd(0); chk("R4 divisor low", c_rdata, 16'h0034);
    rd(4); chk("R4 divisor high", c_rdata, 16'h0012);
    wr(12, 16'h0003);
    rd(4); chk("R4 enable untouched", c_rdata, 0);
  endtask

  task automatic t_ro;
    wr(8, 16'h00FF); wr(20, 16'h00FF); wr(24, 16'h00FF);
    rd(8);  chk("R6 ident", c_rdata, 0);
    rd(24); chk("R6 modem status", c_rdata, 0);
    rd(20); chk("R6 line status", c_rdata, 0);
  endtask

  task automatic t_thr;
    wr(4, 16'h0002); rd(4); chk("R5 enable rw", c_rdata, 16'h0002);
    wr(0, 16'h0141);
    chk("R5 tx_valid", c_txv, 1); chk("R5 tx_data", c_txd, 8'h41);
    chk("R11 tx_evt set", c_txe, 1);
    @(negedge clk); chk("R5 single pulse", tx_valid, 0);
    wr(4, 0); wr(0, 16'h0042);
    chk("R11 tx_evt clear", c_txe, 0); chk("R5 tx_data 2", c_txd, 8'h42);
  endtask

  task automatic t_rx;
    rx_avail = 1'b1; rx_data = 8'h77;
    rd(0); chk("R9 data", c_rdata, 16'h0077); chk("R9 take", c_take, 1);
    rx_avail = 1'b0; rx_data = 8'h11;
    rd(0); chk("R9 keep", c_rdata, 16'h0077); chk("R9 no take", c_take, 0);
  endtask

  task automatic t_loop;
    wr(16, 16'h0010);
    rx_avail = 1'b1; rx_data = 8'h99;
    wr(0, 16'h00C3); chk("R8 no tx_valid", c_txv, 0);
    rd(0); chk("R8 held byte", c_rdata, 16'h00C3); chk("R8 no take", c_take, 0);
    rd(0); chk("R8 keep previous", c_rdata, 16'h00C3); chk("R8 ignore rx", c_take, 0);
    wr(16, 0); rx_avail = 1'b0;
  endtask

  task automatic t_lsr;
    tx_empty = 1'b1; rx_avail = 1'b0;
    rd(20); chk("R10 tx empty", c_rdata, 16'h0060);
    rx_avail = 1'b1;
    rd(20); chk("R10 data ready", c_rdata, 16'h0061);
    rx_avail = 1'b0; tx_empty = 1'b0;
    rd(20); chk("R10 sticky", c_rdata, 16'h0061);
  endtask

  task automatic count_rx(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rx_evt) cnt++;
    end
  endtask

  task automatic t_poll;
    int n;
    rx_avail = 1'b1;
    wr(4, 16'h0001);
    count_rx(64, n); chk("R12 periodic", n, 4);
    rx_avail = 1'b0;
    count_rx(64, n); chk("R12 no status", n, 0);
    rx_avail = 1'b1;
    wr(4, 0);
    count_rx(64, n); chk("R12 stopped", n, 0);
    rx_avail = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset; t_size; t_unmapped; t_plain; t_dlab; t_ro;
    t_thr; t_rx; t_loop; t_lsr; t_poll;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule